// File: doc/BRIEF.md
# Floating-Point Sticky Exception Flag Register

This block keeps the accumulated exception flags of a floating-point control and status register. After every floating-point operation the arithmetic unit presents a strobe with a detailed status vector. When the register's exception-enable bit is set, the block maps the detailed causes onto eight summary flags and ORs them into the stored flags. The stored flags never clear themselves.

Many detailed invalid-operation causes fold into one invalid flag. Some of those causes also raise dedicated flags: signaling NaN, quiet NaN and infinity. After an accepted update, if any of the eight flags is set, the block raises a one-cycle exception request toward the core's trap logic. Software reads and writes the whole register through a simple port. A write is the only way to clear flags, and it takes priority over a hardware update in the same cycle.

Register layout (bit 0 and up):
- bit 0: enable
- bit 1: overflow
- bit 2: underflow
- bit 3: signaling NaN
- bit 4: quiet NaN
- bit 5: divide by zero
- bit 6: inexact
- bit 7: invalid
- bit 8: infinity
- bits above 8: read as zero

Status vector bits:
- 0: signaling NaN
- 1: quiet NaN
- 2: inf minus inf
- 3: inf divided by inf
- 4: zero divided by zero
- 5: inf times zero
- 6: invalid conversion
- 7: invalid compare
- 8: invalid square root
- 9: overflow
- 10: underflow
- 11: divide by zero
- 12: inexact

Top module: `fpx_flag_reg`

## Requirements
- R1: After reset, every register bit reads 0 and `exc_req` is 0.
- R2: While the enable bit (bit 0) is 0, a status strobe changes no register bit and produces no exception request.
- R3: With enable set, any of status bits 0 through 8 sets the invalid flag (register bit 7).
- R4: With enable set, status bit 0 sets the signaling-NaN flag (bit 3), and status bit 1 sets the quiet-NaN flag (bit 4).
- R5: With enable set, status bit 2 or status bit 3 sets the infinity flag (bit 8).
- R6: With enable set, status bits 9, 10, 11 and 12 set register bits 1, 2, 5 and 6 respectively.
- R7: Flags are sticky. A strobe never clears a flag; only a software write changes a flag to 0.
- R8: `exc_req` is high for exactly the one cycle after an accepted strobe (strobe with enable set and no write) when any of bits 8:1 is set after the update. This includes flags that were already set before the strobe. Otherwise `exc_req` is low.
- R9: A software write in the same cycle as a strobe wins. The register takes the written value, the strobe is discarded, and no request follows.
- R10: `rd_data` returns the register with bits above 8 reading 0, and written values for bits above 8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Status strobe from the arithmetic unit |
| st_cause | input | 13 | Detailed status vector, meaningful while st_valid is 1 |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | CSR_W | Software write value |
| rd_data | output | CSR_W | Current register contents |
| exc_req | output | 1 | One-cycle floating-point exception request |

## Verification
The bench drives each invalid cause alone and checks which side flags go with it:
- A mis-wired cause map would set the infinity flag on a conversion fault, or miss the NaN flags.

Disabled strobes carrying every cause must leave the register and the request unchanged, which catches a gate placed on the request but not on the flags. A strobe with an all-zero status over already-set flags must still request an exception; a design that looks only at new causes stays silent there. A write colliding with a strobe must leave exactly the written value and no request, which catches a design that merges the two or lets the strobe win.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  // Detailed status vector positions
  localparam int ST_W     = 13;
  localparam int ST_SNAN  = 0;
  localparam int ST_QNAN  = 1;
  localparam int ST_ISI   = 2;
  localparam int ST_IDI   = 3;
  localparam int ST_ZDZ   = 4;
  localparam int ST_IMZ   = 5;
  localparam int ST_CVT   = 6;
  localparam int ST_CMP   = 7;
  localparam int ST_SQRT  = 8;
  localparam int ST_OVF   = 9;
  localparam int ST_UNF   = 10;
  localparam int ST_DZ    = 11;
  localparam int ST_IX    = 12;

  // Invalid causes occupy a contiguous range
  localparam int INV_LO   = ST_SNAN;
  localparam int INV_HI   = ST_SQRT;

  // Register layout: enable at bit 0, flags above it
  localparam int NFLAG    = 8;
  localparam int CSR_EN   = 0;
  localparam int CSR_FLO  = 1;
  localparam int CSR_USED = CSR_FLO + NFLAG;

  // Packed order matches register bits 8 down to 1
  typedef struct packed {
    logic inf;
    logic inv;
    logic ix;
    logic dz;
    logic qnan;
    logic snan;
    logic unf;
    logic ovf;
  } fpx_flags_t;

endpackage

// File: rtl/fpx_cause_map.sv
module fpx_cause_map
  import fpx_pkg::*;
(
  input  logic [ST_W-1:0] cause,
  output fpx_flags_t      hit
);

  localparam int INV_N = INV_HI - INV_LO + 1;

  logic [INV_N-1:0] inv_src;

  genvar gi;
  generate
    for (gi = 0; gi < INV_N; gi++) begin : g_inv
      assign inv_src[gi] = cause[INV_LO + gi];
    end
  endgenerate

  always_comb begin
    hit      = '0;
    hit.inv  = |inv_src;
    hit.snan = cause[ST_SNAN];
    hit.qnan = cause[ST_QNAN];
    hit.inf  = cause[ST_ISI] | cause[ST_IDI];
    hit.ovf  = cause[ST_OVF];
    hit.unf  = cause[ST_UNF];
    hit.dz   = cause[ST_DZ];
    hit.ix   = cause[ST_IX];
  end

endmodule

// File: rtl/fpx_flag_store.sv
module fpx_flag_store
  import fpx_pkg::*;
#(
  parameter int CSR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  fpx_flags_t       hit,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  output logic             en_q,
  output fpx_flags_t       flags_q,
  output fpx_flags_t       flags_nxt,
  output logic             upd
);

  logic       en_nxt;
  logic       ld;
  fpx_flags_t wr_flags;

  assign wr_flags = fpx_flags_t'(wr_data[CSR_USED-1:CSR_FLO]);
  assign upd      = st_valid & en_q & ~wr_en;
  assign ld       = wr_en | upd;

  always_comb begin
    en_nxt    = en_q;
    flags_nxt = flags_q;
    if (wr_en) begin
      en_nxt    = wr_data[CSR_EN];
      flags_nxt = wr_flags;
    end else if (upd) begin
      flags_nxt = flags_q | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      flags_q <= '0;
    end else if (ld) begin
      en_q    <= en_nxt;
      flags_q <= flags_nxt;
    end
  end

  // R2
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !en_q && !wr_en) |=> $stable(flags_q));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R9
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (flags_q == $past(wr_flags)) && (en_q == $past(wr_data[CSR_EN])));

endmodule

// File: rtl/fpx_exc_pulse.sv
module fpx_exc_pulse
  import fpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  fpx_flags_t flags_nxt,
  output logic       exc_req
);

  logic req_nxt;

  always_comb begin
    req_nxt = upd & (|flags_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req <= 1'b0;
    end else begin
      exc_req <= req_nxt;
    end
  end

  // R8
  req_after_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(upd));

endmodule

// File: rtl/fpx_flag_reg.sv
module fpx_flag_reg
  import fpx_pkg::*;
#(
  parameter int CSR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic [ST_W-1:0]  st_cause,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  output logic [CSR_W-1:0] rd_data,
  output logic             exc_req
);

  localparam int PAD_W = CSR_W - CSR_USED;

  fpx_flags_t hit;
  fpx_flags_t flags_q;
  fpx_flags_t flags_nxt;
  logic       en_q;
  logic       upd;

  fpx_cause_map u_map (
    .cause (st_cause),
    .hit   (hit)
  );

  fpx_flag_store #(.CSR_W(CSR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .hit       (hit),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .en_q      (en_q),
    .flags_q   (flags_q),
    .flags_nxt (flags_nxt),
    .upd       (upd)
  );

  fpx_exc_pulse u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (upd),
    .flags_nxt (flags_nxt),
    .exc_req   (exc_req)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, flags_q, en_q};
    end else begin : g_nopad
      assign rd_data = {flags_q, en_q};
    end
  endgenerate

  // R3
  inv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && en_q && !wr_en && |st_cause[INV_HI:INV_LO]) |=> rd_data[CSR_FLO+6]);

  // R4
  snan_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && en_q && !wr_en && st_cause[ST_SNAN]) |=> rd_data[CSR_FLO+2]);

  // R5
  inf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && en_q && !wr_en && (st_cause[ST_ISI] || st_cause[ST_IDI])) |=> rd_data[CSR_FLO+7]);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && en_q && !wr_en && st_cause[ST_OVF]) |=> rd_data[CSR_FLO]);

  // R8
  req_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (rd_data[CSR_USED-1:CSR_FLO] != '0));

  // R10
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> CSR_USED) == '0);

endmodule

// File: tb/tb_fpx_flag_reg.sv
module tb_fpx_flag_reg;
  import fpx_pkg::*;

  localparam int CSR_W = 32;
  localparam int NV    = 19;
  localparam int WDOG  = 20000;

  // Each entry: {init[8:0], cause[12:0], expect[8:0], req}
  localparam logic [31:0] VEC [NV] = '{
    {9'h001, 13'h0001, 9'h089, 1'b1},  // R3 R4 snan
    {9'h001, 13'h0002, 9'h091, 1'b1},  // R3 R4 qnan
    {9'h001, 13'h0004, 9'h181, 1'b1},  // R3 R5 inf-inf
    {9'h001, 13'h0008, 9'h181, 1'b1},  // R3 R5 inf/inf
    {9'h001, 13'h0010, 9'h081, 1'b1},  // R3 0/0
    {9'h001, 13'h0020, 9'h081, 1'b1},  // R3 inf*0
    {9'h001, 13'h0040, 9'h081, 1'b1},  // R3 conversion
    {9'h001, 13'h0080, 9'h081, 1'b1},  // R3 compare
    {9'h001, 13'h0100, 9'h081, 1'b1},  // R3 sqrt
    {9'h001, 13'h0200, 9'h003, 1'b1},  // R6 overflow
    {9'h001, 13'h0400, 9'h005, 1'b1},  // R6 underflow
    {9'h001, 13'h0800, 9'h021, 1'b1},  // R6 div by zero
    {9'h001, 13'h1000, 9'h041, 1'b1},  // R6 inexact
    {9'h001, 13'h0000, 9'h001, 1'b0},  // R8 nothing set
    {9'h043, 13'h0000, 9'h043, 1'b1},  // R7 R8 sticky old flags
    {9'h000, 13'h1FFF, 9'h000, 1'b0},  // R2 disabled
    {9'h1FE, 13'h0201, 9'h1FE, 1'b0},  // R2 disabled with flags
    {9'h001, 13'h1FFF, 9'h1FF, 1'b1},  // R3 R6 all causes
    {9'h005, 13'h0800, 9'h025, 1'b1}   // R7 accumulate
  };

  logic             clk;
  logic             rst_n;
  logic             st_valid;
  logic [ST_W-1:0]  st_cause;
  logic             wr_en;
  logic [CSR_W-1:0] wr_data;
  logic [CSR_W-1:0] rd_data;
  logic             exc_req;

  int n_chk;
  int n_bad;
  int cyc;

  fpx_flag_reg #(.CSR_W(CSR_W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_cause (st_cause),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .exc_req  (exc_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WDOG);
      finish_run();
    end
  end

  task automatic do_write(input logic [CSR_W-1:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0;
    rst_n = 1'b0; st_valid = 1'b0; st_cause = '0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 0);
    check("R1 exc_req", exc_req, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      do_write({23'h0, VEC[i][31:23]});
      st_valid = 1'b1;
      st_cause = VEC[i][22:10];
      @(negedge clk);
      st_valid = 1'b0;
      st_cause = '0;
      check($sformatf("R3-table vec %0d rd_data", i), rd_data, {55'h0, VEC[i][9:1]});
      check($sformatf("R8 vec %0d exc_req", i), exc_req, VEC[i][0]);
      @(negedge clk);
      check($sformatf("R8 vec %0d pulse end", i), exc_req, 0);
    end

    // R9 write collides with strobe
    do_write(32'h0000_0001);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_0009;
    st_valid = 1'b1; st_cause = 13'h1FFF;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; st_valid = 1'b0; st_cause = '0;
    check("R9 rd_data", rd_data, 32'h9);
    check("R9 exc_req", exc_req, 0);

    // R10 upper bits ignored
    do_write(32'hFFFF_FFFF);
    check("R10 rd_data", rd_data, 32'h1FF);

    // R7 clear only by write
    do_write(32'h0000_0001);
    check("R7 cleared", rd_data, 32'h1);

    // R8 back-to-back strobes: request each cycle
    @(negedge clk);
    st_valid = 1'b1; st_cause = 13'h1000;
    @(negedge clk);
    st_cause = 13'h0000;
    check("R8 first req", exc_req, 1);
    @(negedge clk);
    st_valid = 1'b0;
    check("R8 second req", exc_req, 1);
    check("R7 kept", rd_data, 32'h41);
    @(negedge clk);
    check("R8 quiet", exc_req, 0);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 async clear", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", exc_req, 0);

    finish_run();
  end

endmodule